// File: doc/BRIEF.md
# Double-Buffered Asymmetric PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter that is clocked by the module clock. Software programs a period and a compare value, both as counts of that clock, through a small memory-mapped register port. The compare value decides how many cycles of each period sit at the active level. A polarity control decides whether the active level is high or low.

Each of the two timing values has two copies. The live copy drives the waveform. The staging copy can be written at any time. Staged values reach the live copy only on the cycle where the counter wraps, so retiming a running output never shortens or breaks the period that is under way. The live copies can also be written directly, which is the normal way to load them before the counter is started. A single 16-bit control word holds the counter run bit, the waveform enable bit and the polarity bit. It also has two spare bits that select a synchronisation source. These two bits are stored and read back but have no effect on the output.

Top module: `apwm_shadow`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `pwm_out` is low.
- R2: Register offsets are fixed. Live period is at 0x08, live compare at 0x0C, staged period at 0x10 and staged compare at 0x14; each is 32 bits. The control word is at 0x2A, is 16 bits wide, is written from `wdata[15:0]` and reads back zero-extended. A write lands on the clock edge where `wr_en` is high. `rdata` shows the addressed register's current contents in the same cycle.
- R3: Any other offset reads as zero, and a write to it changes no register.
- R4: The counter advances only while control bit 4 (run) is set. It counts from 0 to the live period minus one and then wraps to 0. A live period of 0 or 1 keeps the counter at 0.
- R5: While control bit 9 (waveform enable) is clear, `pwm_out` is low whatever the counter, compare and polarity hold.
- R6: With bit 9 set and bit 10 clear, `pwm_out` is high in the cycle after the counter holds a value below the live compare, and low otherwise. The output is registered, so it lags the counter by exactly one cycle.
- R7: With bits 9 and 10 both set, the level is inverted: `pwm_out` is low for counter values below the live compare and high for the rest.
- R8: A live compare at or above the live period gives a constant active level. A live compare of 0 gives a constant inactive level. A period of 1 with a compare of 1 is the shortest usable setting and gives a constant active level.
- R9: On a wrap cycle, both staged values are copied into the live registers together, but only if a staged register has been written since the last copy. A staged write on the wrap cycle itself waits for the next wrap.
- R10: A write to a live register takes effect on its clock edge even while the counter runs. If it coincides with a staged copy, the direct write wins for that register.
- R11: Writing a control word with bits 4 and 9 both clear freezes the counter at its current value and drives `pwm_out` low. Setting them again resumes counting from the frozen value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; counter and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rdata | output | 32 | Contents of the addressed register, combinational |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Register reads are combinational, so a value written on one edge is due on `rdata` in the same cycle as the next sample after that edge. The output depends on the counter through one register, so the level due after an edge is a function of the counter, compare and control values held before that edge. Staged values change the waveform only from the edge after a wrap. The bench keeps a cycle-by-cycle reference state that it advances on each rising edge from the inputs it drove. It compares the outputs at the following falling edge, and so applies each of these latencies without guessing.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

    // Register byte offsets; software decodes these
    localparam int unsigned OFS_PER_LIVE  = 32'h08;
    localparam int unsigned OFS_CMP_LIVE  = 32'h0C;
    localparam int unsigned OFS_PER_STAGE = 32'h10;
    localparam int unsigned OFS_CMP_STAGE = 32'h14;
    localparam int unsigned OFS_CTRL      = 32'h2A;

    // Control word bit positions
    localparam int unsigned CTL_RUN  = 4;
    localparam int unsigned CTL_WAVE = 9;
    localparam int unsigned CTL_INV  = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PER_LIVE,
        SEL_CMP_LIVE,
        SEL_PER_STAGE,
        SEL_CMP_STAGE,
        SEL_CTRL
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        case (ofs)
            OFS_PER_LIVE:  return SEL_PER_LIVE;
            OFS_CMP_LIVE:  return SEL_CMP_LIVE;
            OFS_PER_STAGE: return SEL_PER_STAGE;
            OFS_CMP_STAGE: return SEL_CMP_STAGE;
            OFS_CTRL:      return SEL_CTRL;
            default:       return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/apwm_regfile.sv
module apwm_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              wrap,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] per_live,
    output logic [DATA_W-1:0] cmp_live,
    output logic [CTRL_W-1:0] ctrl
);
    import apwm_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] per_live;
        logic [DATA_W-1:0] cmp_live;
        logic [DATA_W-1:0] per_stage;
        logic [DATA_W-1:0] cmp_stage;
        logic [CTRL_W-1:0] ctrl;
        logic              pend;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;

    always_comb begin
        sel    = decode_ofs(32'(addr));
        regs_d = regs_q;
        // staged copy first, so a direct live write on the same edge wins
        if (wrap && regs_q.pend) begin
            regs_d.per_live = regs_q.per_stage;
            regs_d.cmp_live = regs_q.cmp_stage;
            regs_d.pend     = 1'b0;
        end
        if (wr_en) begin
            case (sel)
                SEL_PER_LIVE:  regs_d.per_live = wdata;
                SEL_CMP_LIVE:  regs_d.cmp_live = wdata;
                SEL_PER_STAGE: begin
                    regs_d.per_stage = wdata;
                    regs_d.pend      = 1'b1;
                end
                SEL_CMP_STAGE: begin
                    regs_d.cmp_stage = wdata;
                    regs_d.pend      = 1'b1;
                end
                SEL_CTRL:      regs_d.ctrl = wdata[CTRL_W-1:0];
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_PER_LIVE:  rdata = regs_q.per_live;
            SEL_CMP_LIVE:  rdata = regs_q.cmp_live;
            SEL_PER_STAGE: rdata = regs_q.per_stage;
            SEL_CMP_STAGE: rdata = regs_q.cmp_stage;
            SEL_CTRL:      rdata = DATA_W'(regs_q.ctrl);
            default:       rdata = '0;
        endcase
    end

    assign per_live = regs_q.per_live;
    assign cmp_live = regs_q.cmp_live;
    assign ctrl     = regs_q.ctrl;

endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] per_live,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } cnt_t;

    cnt_t          cnt_d, cnt_q;
    logic [DATA_W:0] next_ext;

    always_comb begin
        next_ext = {1'b0, cnt_q.cnt} + {{DATA_W{1'b0}}, 1'b1};
        wrap     = run && (next_ext >= {1'b0, per_live});
        cnt_d    = cnt_q;
        if (run) begin
            if (wrap) cnt_d.cnt = '0;
            else      cnt_d.cnt = next_ext[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q.cnt;

endmodule

// File: rtl/apwm_wavegen.sv
module apwm_wavegen #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wave_en,
    input  logic              invert,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] cmp_live,
    output logic              pwm
);
    typedef struct packed {
        logic out;
    } wave_t;

    wave_t wave_d, wave_q;

    always_comb begin
        wave_d.out = wave_en && ((cnt < cmp_live) ^ invert);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= '0;
        else        wave_q <= wave_d;
    end

    assign pwm = wave_q.out;

endmodule

// File: rtl/apwm_shadow.sv
module apwm_shadow #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);
    import apwm_pkg::*;

    logic [DATA_W-1:0] per_live, cmp_live, cnt_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              wrap;

    apwm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .wrap     (wrap),
        .rdata    (rdata),
        .per_live (per_live),
        .cmp_live (cmp_live),
        .ctrl     (ctrl_q)
    );

    apwm_counter #(.DATA_W(DATA_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q[CTL_RUN]),
        .per_live (per_live),
        .cnt      (cnt_q),
        .wrap     (wrap)
    );

    apwm_wavegen #(.DATA_W(DATA_W)) wave_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wave_en  (ctrl_q[CTL_WAVE]),
        .invert   (ctrl_q[CTL_INV]),
        .cnt      (cnt_q),
        .cmp_live (cmp_live),
        .pwm      (pwm_out)
    );

endmodule

// File: rtl/apwm_shadow_chk.sv
module apwm_shadow_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              pwm_out,
    input logic [DATA_W-1:0] cnt_q,
    input logic [DATA_W-1:0] per_live,
    input logic [DATA_W-1:0] cmp_live,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              wrap
);
    import apwm_pkg::*;

    logic undef_ofs, live_per_wr, live_cmp_wr;
    assign undef_ofs   = decode_ofs(32'(addr)) == SEL_NONE;
    assign live_per_wr = wr_en && decode_ofs(32'(addr)) == SEL_PER_LIVE;
    assign live_cmp_wr = wr_en && decode_ofs(32'(addr)) == SEL_CMP_LIVE;

    assert_undef_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        undef_ofs |-> rdata == '0);

    assert_undef_write_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && undef_ofs && !wrap) |=> ($stable(per_live) && $stable(cmp_live) && $stable(ctrl_q)));

    assert_frozen_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTL_RUN] |=> $stable(cnt_q));

    assert_low_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTL_WAVE] |=> !pwm_out);

    assert_live_per_moves_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_live) |-> ($past(wrap) || $past(live_per_wr)));

    assert_live_cmp_moves_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_live) |-> ($past(wrap) || $past(live_cmp_wr)));

    assert_stop_drives_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTL_RUN] && !ctrl_q[CTL_WAVE]) |=> (!pwm_out && $stable(cnt_q)));

endmodule

bind apwm_shadow apwm_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rdata    (rdata),
    .pwm_out  (pwm_out),
    .cnt_q    (cnt_q),
    .per_live (per_live),
    .cmp_live (cmp_live),
    .ctrl_q   (ctrl_q),
    .wrap     (wrap)
);

// File: tb/apwm_shadow_tb_top.sv
module apwm_shadow_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic        pwm_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    apwm_shadow dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_per, m_cmp, m_sper, m_scmp, m_cnt;
    logic [15:0] m_ctrl;
    logic        m_pend, m_out;

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h08:   return m_per;
            8'h0C:   return m_cmp;
            8'h10:   return m_sper;
            8'h14:   return m_scmp;
            8'h2A:   return {16'h0, m_ctrl};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_level(input logic [31:0] c, input logic [31:0] k, input logic [15:0] ct);
        return ct[9] && ((c < k) ^ ct[10]);
    endfunction

    task automatic model_reset();
        m_per = 0; m_cmp = 0; m_sper = 0; m_scmp = 0; m_cnt = 0;
        m_ctrl = 0; m_pend = 0; m_out = 0;
    endtask

    task automatic model_edge();
        logic        wr;
        logic        nout;
        logic [31:0] ncnt;
        wr   = m_ctrl[4] && (longint'(m_cnt) + 1 >= longint'(m_per));
        nout = exp_level(m_cnt, m_cmp, m_ctrl);
        ncnt = m_cnt;
        if (m_ctrl[4]) ncnt = wr ? 32'h0 : m_cnt + 1;
        if (wr && m_pend) begin
            m_per = m_sper; m_cmp = m_scmp; m_pend = 0;
        end
        if (wr_en) begin
            case (addr)
                8'h08: m_per = wdata;
                8'h0C: m_cmp = wdata;
                8'h10: begin m_sper = wdata; m_pend = 1; end
                8'h14: begin m_scmp = wdata; m_pend = 1; end
                8'h2A: m_ctrl = wdata[15:0];
                default: ;
            endcase
        end
        m_cnt = ncnt;
        m_out = nout;
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        if (!rst_n) model_reset();
        else        model_edge();
        @(negedge clk);
        check(tag, "pwm_out", {31'h0, pwm_out}, {31'h0, m_out});
        check(tag, "rdata", rdata, exp_read(addr));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        addr = a; wdata = d; wr_en = 1'b1;
        cycle(tag);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        addr = a;
        cycle(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        // R1: reset state
        idle(2, "R1");
        rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1"); rd(8'h14, "R1"); rd(8'h2A, "R1");
        rst_n = 1'b1;
        idle(3, "R1");

        // R2: register access
        wr(8'h08, 32'hDEAD_BEEF, "R2"); rd(8'h08, "R2");
        wr(8'h0C, 32'h1234_5678, "R2"); rd(8'h0C, "R2");
        wr(8'h10, 32'hA5A5_0F0F, "R2"); rd(8'h10, "R2");
        wr(8'h14, 32'h0000_FFFF, "R2"); rd(8'h14, "R2");
        wr(8'h2A, 32'hABCD_C0C3, "R2"); rd(8'h2A, "R2");
        wr(8'h2A, 32'h0, "R2");

        // R3: undefined offsets
        wr(8'h04, 32'hFFFF_FFFF, "R3"); rd(8'h04, "R3");
        wr(8'h2C, 32'hFFFF_FFFF, "R3"); rd(8'h2C, "R3");
        wr(8'h18, 32'h5555_5555, "R3"); rd(8'h18, "R3");
        rd(8'h08, "R3"); rd(8'h0C, "R3"); rd(8'h2A, "R3");

        // R5: run without waveform enable
        wr(8'h08, 32'd4, "R5"); wr(8'h0C, 32'd2, "R5");
        wr(8'h2A, 32'h0010, "R5");
        idle(10, "R5");
        wr(8'h2A, 32'h0400, "R5"); idle(4, "R5");

        // R4 R6: normal polarity running
        wr(8'h2A, 32'h0000, "R4"); wr(8'h08, 32'd5, "R4");
        wr(8'h2A, 32'h0210, "R4 R6");
        idle(14, "R4 R6");

        // R7: inverted
        wr(8'h2A, 32'h0610, "R7");
        idle(12, "R7");

        // R8: compare extremes, shortest period
        wr(8'h0C, 32'd0, "R8"); idle(8, "R8");
        wr(8'h2A, 32'h0210, "R8"); idle(8, "R8");
        wr(8'h0C, 32'd9, "R8"); idle(8, "R8");
        wr(8'h08, 32'd1, "R8"); wr(8'h0C, 32'd1, "R8"); idle(6, "R4 R8");
        wr(8'h08, 32'd0, "R4"); idle(4, "R4");

        // R9: staged update at wrap
        wr(8'h08, 32'd6, "R9"); wr(8'h0C, 32'd3, "R9");
        wr(8'h10, 32'd3, "R9"); wr(8'h14, 32'd1, "R9");
        for (int i = 0; i < 8; i++) begin rd(8'h08, "R9"); rd(8'h0C, "R9"); end
        wr(8'h08, 32'd7, "R9"); wr(8'h0C, 32'd4, "R9");
        for (int i = 0; i < 8; i++) rd(8'h08, "R9");

        // R10: live write while running
        wr(8'h08, 32'd3, "R10"); idle(5, "R10");
        wr(8'h0C, 32'd2, "R10"); idle(6, "R10");

        // R11: stop and resume
        wr(8'h08, 32'd8, "R11"); wr(8'h0C, 32'd4, "R11");
        idle(3, "R11");
        wr(8'h2A, 32'h0000, "R11"); idle(6, "R11");
        wr(8'h2A, 32'h0210, "R11"); idle(10, "R11");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned k;
            logic [7:0] a;
            logic [31:0] d;
            k = $urandom_range(0, 9);
            case (k)
                0: a = 8'h08;
                1: a = 8'h0C;
                2, 3: a = 8'h10;
                4, 5: a = 8'h14;
                6: a = 8'h2A;
                7: a = 8'h28;
                default: a = 8'h00;
            endcase
            if (a == 8'h2A) begin
                case ($urandom_range(0, 5))
                    0: d = 32'h0000;
                    1: d = 32'h0010;
                    2: d = 32'h0200;
                    3: d = 32'h0610;
                    4: d = 32'h02D0;
                    default: d = 32'h0210;
                endcase
            end else begin
                d = 32'($urandom_range(0, 12));
            end
            if (k <= 7) wr(a, d, "R6 R7 R8 R9 R10");
            idle(int'($urandom_range(0, 6)), "R4 R6 R7 R9");
            rd(8'($urandom_range(0, 48)), "R2 R3");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule